// File: doc/BRIEF.md
# Stage-1 Translation Table Walker

This block turns a 64-bit virtual address into a physical address by reading translation descriptors from memory, one level at a time. A request supplies the address, the translation enable bit, a translation control word and two table base values. When translation is off, the address passes straight through. When it is on, the walker picks a half of the address space by the top address bit. It checks that the address fits the size configured for that half and decodes the page granule. It then chooses the first table level and reads one 64-bit descriptor per level until it reaches a page or a fault.

The request side uses a start/busy/done handshake. The memory side is a valid/ready read port with at most one read in flight, and a response strobe that carries the descriptor. The walker reports a fault for an out-of-range address, a reserved granule code, an invalid descriptor or a block descriptor. There is no caching of results and no permission decoding.

Top module: `tt_walker`

## Requirements
- R1: With `mmu_en` low, a start produces `done` on the next cycle with `pa` equal to `va`, no fault and no read request.
- R2: `va[63]` selects the half: 0 walks from `base_lo`, 1 walks from `base_hi`.
- R3: The size value N is `tcr[5:0]` for the lower half and `tcr[21:16]` for the upper half, giving a (64−N)-bit space. Bits 63 down to 64−N must all equal `va[63]`, or the walk faults with no read.
- R4: For the lower half, the granule code `tcr[15:14]` means 00 = 4 KiB, 01 = 64 KiB, 10 = 16 KiB; 11 is reserved and faults with no read.
- R5: For the upper half, the granule code `tcr[31:30]` means 10 = 4 KiB, 01 = 16 KiB, 11 = 64 KiB; 00 is reserved and faults with no read.
- R6: With a granule of 2^G bytes, each level takes G−3 index bits. Level 3 indexes from bit G, and each level above it sits G−3 bits higher. The read address is the table base plus the index times 8.
- R7: Let S be the space width. With 4 KiB pages, the walk starts at level 0 if S exceeds the level-0 shift, at level 1 if S exceeds the level-1 shift, and at level 2 otherwise. With 16 KiB or 64 KiB pages, it starts at level 1 if S exceeds the level-1 shift, and at level 2 otherwise. One read is made per level down to level 3.
- R8: A descriptor whose bits [1:0] are not 11 ends the walk with a fault. This covers bit 0 clear and the block code 01. `fault` is only ever high together with `done`.
- R9: A descriptor with bits [1:0] = 11 gives the next table base below level 3. At level 3 it gives the page base. In both cases bits [G−1:0] are cleared. The result `pa` is the page base ORed with `va[G−1:0]`.
- R10: `done` is one cycle long and coincides with `busy` low. A start while busy is ignored. `pa` changes only on a successful completion and otherwise holds.
- R11: While `rd_valid` is high and `rd_ready` is low, the request and `rd_addr` stay unchanged.
- R12: Reset clears `busy`, `done`, `fault`, `rd_valid` and `pa`. A reset during a walk returns the walker to idle without a `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a translation (sampled when idle) |
| va | input | 64 | Virtual address to translate |
| mmu_en | input | 1 | Translation enable |
| tcr | input | 64 | Translation control word (size and granule fields) |
| base_lo | input | 64 | Table base for the lower half |
| base_hi | input | 64 | Table base for the upper half |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | One-cycle fault strobe, with done |
| pa | output | 64 | Physical address, held until the next success |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 64 | Descriptor address |
| rsp_valid | input | 1 | Descriptor returned |
| rsp_data | input | 64 | Descriptor value |

## Verification
The assertions check, on every cycle, the port-level protocol. A stalled request keeps its address. Fault never appears without done, and done never overlaps busy. The physical address moves only on a successful finish. A disabled or misconfigured start finishes in one cycle without touching memory. The arithmetic cannot be shown this way, so the bench's scenarios cover it: which base is chosen, the level at which the walk starts, the index of every entry, how descriptor bits are cleared and how the offset is merged. The bench compares the read count, the first entry address and the result against its own walk over a table image it builds. Reset in the middle of a walk and a start issued while busy are also shown only by directed scenarios.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // log2 of the descriptor size in bytes
  localparam int unsigned ENT_LOG2 = 3;
  localparam logic [1:0]  LAST_LVL = 2'd3;

  typedef enum logic [1:0] {
    GR_4K  = 2'd0,
    GR_16K = 2'd1,
    GR_64K = 2'd2,
    GR_BAD = 2'd3
  } gran_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;

  // page offset width for a granule
  function automatic logic [4:0] gran_ofs(gran_e g);
    case (g)
      GR_16K:  return 5'd14;
      GR_64K:  return 5'd16;
      default: return 5'd12;
    endcase
  endfunction

  // lowest VA bit indexed at a level: ofs + (3 - lvl) * (ofs - 3)
  function automatic logic [6:0] lvl_shift(logic [4:0] ofs, logic [1:0] lvl);
    logic [6:0] per;
    logic [6:0] up;
    per = {2'b00, ofs} - 7'd3;
    up  = 7'd3 - {5'b00000, lvl};
    return {2'b00, ofs} + per * up;
  endfunction

  function automatic logic [63:0] low_mask(logic [6:0] n);
    return (64'd1 << n) - 64'd1;
  endfunction

endpackage

// File: rtl/tw_cfg_decode.sv
module tw_cfg_decode
  import tw_pkg::*;
#(
  parameter int AW        = 64,
  parameter int SZ_W      = 6,
  parameter int LO_SZ_LSB = 0,
  parameter int HI_SZ_LSB = 16,
  parameter int LO_TG_LSB = 14,
  parameter int HI_TG_LSB = 30
) (
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] tcr,
  input  logic [AW-1:0] base_lo,
  input  logic [AW-1:0] base_hi,
  output logic [AW-1:0] tbl_base,
  output logic [4:0]    ofs_bits,
  output logic [1:0]    start_lvl,
  output logic          bad_gran,
  output logic          noncanon
);

  localparam int VW = $clog2(AW) + 1;

  logic            hi_half;
  logic [SZ_W-1:0] sz;
  logic [1:0]      tg;
  gran_e           gran;
  logic [VW-1:0]   vas;
  logic [VW-1:0]   l0_sh;
  logic [VW-1:0]   l1_sh;
  logic [AW-1:0]   top_mask;
  logic            unused_tcr;

  assign unused_tcr = ^tcr;

  always_comb begin
    hi_half  = va[AW-1];
    sz       = hi_half ? tcr[HI_SZ_LSB +: SZ_W] : tcr[LO_SZ_LSB +: SZ_W];
    vas      = VW'(AW) - VW'(sz);
    top_mask = {AW{1'b1}} << vas;
    noncanon = hi_half ? ((va & top_mask) != top_mask) : ((va & top_mask) != '0);

    tg = hi_half ? tcr[HI_TG_LSB +: 2] : tcr[LO_TG_LSB +: 2];
    if (!hi_half) begin
      case (tg)
        2'b00:   gran = GR_4K;
        2'b01:   gran = GR_64K;
        2'b10:   gran = GR_16K;
        default: gran = GR_BAD;
      endcase
    end else begin
      case (tg)
        2'b10:   gran = GR_4K;
        2'b01:   gran = GR_16K;
        2'b11:   gran = GR_64K;
        default: gran = GR_BAD;
      endcase
    end
    bad_gran = (gran == GR_BAD);

    ofs_bits = gran_ofs(gran);
    l0_sh    = VW'(lvl_shift(ofs_bits, 2'd0));
    l1_sh    = VW'(lvl_shift(ofs_bits, 2'd1));
    if (gran == GR_4K && vas > l0_sh)
      start_lvl = 2'd0;
    else if (vas > l1_sh)
      start_lvl = 2'd1;
    else
      start_lvl = 2'd2;

    tbl_base = hi_half ? base_hi : base_lo;
  end

endmodule

// File: rtl/tw_entry_addr.sv
module tw_entry_addr
  import tw_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] va,
  input  logic [4:0]    ofs_bits,
  input  logic [1:0]    lvl,
  output logic [AW-1:0] entry_addr
);

  localparam int VW = $clog2(AW) + 1;

  logic [VW-1:0] sh;
  logic [AW-1:0] idx;

  always_comb begin
    sh         = VW'(lvl_shift(ofs_bits, lvl));
    idx        = (va >> sh) & AW'(low_mask(7'(ofs_bits) - 7'd3));
    entry_addr = tbl_base + (idx << ENT_LOG2);
  end

endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tw_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] va,
  input  logic          mmu_en,
  input  logic [AW-1:0] tcr,
  input  logic [AW-1:0] base_lo,
  input  logic [AW-1:0] base_hi,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] pa,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data
);

  walk_st_e      st;
  logic [AW-1:0] va_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] pa_q;
  logic [4:0]    ofs_q;
  logic [1:0]    lvl_q;
  logic          done_q;
  logic          fault_q;

  logic [AW-1:0] dec_base;
  logic [4:0]    dec_ofs;
  logic [1:0]    dec_lvl;
  logic          dec_bad_gran;
  logic          dec_noncanon;
  logic [AW-1:0] entry_addr;

  // named events for the assertions
  logic          take_start;
  logic          cfg_fault;
  logic          rsp_here;
  logic          desc_ok;
  logic          at_last;
  logic          hit_page;
  logic          go_down;
  logic          desc_fault;
  logic [AW-1:0] ofs_mask;

  tw_cfg_decode #(.AW(AW)) u_dec (
    .va        (va),
    .tcr       (tcr),
    .base_lo   (base_lo),
    .base_hi   (base_hi),
    .tbl_base  (dec_base),
    .ofs_bits  (dec_ofs),
    .start_lvl (dec_lvl),
    .bad_gran  (dec_bad_gran),
    .noncanon  (dec_noncanon)
  );

  tw_entry_addr #(.AW(AW)) u_ent (
    .tbl_base   (base_q),
    .va         (va_q),
    .ofs_bits   (ofs_q),
    .lvl        (lvl_q),
    .entry_addr (entry_addr)
  );

  assign take_start = (st == ST_IDLE) && start;
  assign cfg_fault  = dec_bad_gran || dec_noncanon;
  assign rsp_here   = (st == ST_WAIT) && rsp_valid;
  assign desc_ok    = (rsp_data[1:0] == 2'b11);
  assign at_last    = (lvl_q == LAST_LVL);
  assign hit_page   = rsp_here && desc_ok && at_last;
  assign go_down    = rsp_here && desc_ok && !at_last;
  assign desc_fault = rsp_here && !desc_ok;
  assign ofs_mask   = AW'(low_mask(7'(ofs_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      ofs_q   <= 5'd12;
      lvl_q   <= 2'd0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take_start) begin
            va_q <= va;
            if (!mmu_en) begin
              pa_q   <= va;
              done_q <= 1'b1;
            end else if (cfg_fault) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
            end else begin
              base_q <= dec_base;
              ofs_q  <= dec_ofs;
              lvl_q  <= dec_lvl;
              st     <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (rd_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (hit_page) begin
            pa_q   <= (rsp_data & ~ofs_mask) | (va_q & ofs_mask);
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else if (go_down) begin
            base_q <= rsp_data & ~ofs_mask;
            lvl_q  <= lvl_q + 2'd1;
            st     <= ST_REQ;
          end else if (desc_fault) begin
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign fault    = fault_q;
  assign pa       = pa_q;
  assign rd_valid = (st == ST_REQ);
  assign rd_addr  = entry_addr;

  AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    take_start && !mmu_en |=> done && !fault && !rd_valid && pa == $past(va)); // R1

  AST_CFG_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    take_start && mmu_en && cfg_fault |=> done && fault && !rd_valid); // R3

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_PA_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pa) |-> done && !fault); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R11

endmodule

// File: tb/sim_tt_walker.sv
module sim_tt_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mmu_en = 1'b0;
  logic [63:0] va = '0, tcr = '0, base_lo = '0, base_hi = '0;
  logic        rd_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  wire         busy, done, fault, rd_valid;
  wire  [63:0] pa, rd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .mmu_en(mmu_en),
    .tcr(tcr), .base_lo(base_lo), .base_hi(base_hi), .busy(busy),
    .done(done), .fault(fault), .pa(pa), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  logic [63:0] mem [logic [63:0]];

  int          checks = 0;
  int          errors = 0;
  int          reads_seen = 0;
  int          done_cnt = 0;
  logic [63:0] first_addr = '0;
  logic        pend = 1'b0;
  int          dly = 0;
  logic [63:0] paddr = '0;
  logic        stall = 1'b0;
  logic [63:0] stall_addr = '0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  // memory responder: decisions taken on the falling edge
  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (!rst_n) begin
      pend  = 1'b0;
      stall = 1'b0;
      rd_ready = 1'b0;
    end else begin
      if (stall) begin
        checks++;
        if (!(rd_valid && rd_addr == stall_addr)) begin
          errors++;
          $display("FAIL R11 stalled request changed: actual %h expected %h", rd_addr, stall_addr);
        end
      end
      if (pend) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem_rd(paddr);
          pend      = 1'b0;
        end else dly--;
        rd_ready = 1'b0;
        stall    = 1'b0;
      end else begin
        rd_ready = ($urandom % 4) != 0;
        stall    = rd_valid && !rd_ready;
        stall_addr = rd_addr;
        if (rd_valid && rd_ready) begin
          pend  = 1'b1;
          paddr = rd_addr;
          dly   = $urandom % 3;
          if (reads_seen == 0) first_addr = rd_addr;
          reads_seen++;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && done) done_cnt++;

  // configuration as the requirements define it
  function automatic void cfg_info(input logic [63:0] v, input logic [63:0] t,
                                   output bit hi, output int pg, output int bits,
                                   output int st, output bit bad);
    logic [5:0] sz;
    logic [1:0] tg;
    int per;
    hi  = v[63];
    sz  = hi ? t[21:16] : t[5:0];
    tg  = hi ? t[31:30] : t[15:14];
    bits = 64 - int'(sz);
    bad = 0;
    pg  = 12;
    if (!hi) begin
      if (tg == 2'b00) pg = 12; else if (tg == 2'b01) pg = 16;
      else if (tg == 2'b10) pg = 14; else bad = 1;
    end else begin
      if (tg == 2'b10) pg = 12; else if (tg == 2'b01) pg = 14;
      else if (tg == 2'b11) pg = 16; else bad = 1;
    end
    per = pg - 3;
    st = 2;
    if (bits > pg + 2 * per) st = 1;
    if (pg == 12 && bits > pg + 3 * per) st = 0;
    for (int b = bits; b < 64; b++) if (v[b] != hi) bad = 1;
  endfunction

  function automatic logic [63:0] ent_addr(input logic [63:0] tbl, input logic [63:0] v,
                                           input int pg, input int lvl);
    int per;
    int sh;
    logic [63:0] ix;
    per = pg - 3;
    sh  = pg + per * (3 - lvl);
    ix  = (v >> sh) % (64'd1 << per);
    return tbl + ix * 64'd8;
  endfunction

  function automatic void ref_walk(input logic [63:0] v, input bit en, input logic [63:0] t,
                                   input logic [63:0] blo, input logic [63:0] bhi,
                                   output bit ef, output logic [63:0] epa,
                                   output int er, output logic [63:0] efirst);
    bit hi, bad;
    int pg, bits, st;
    logic [63:0] tbl, a, d;
    ef = 0; epa = 0; er = 0; efirst = 0;
    if (!en) begin epa = v; return; end
    cfg_info(v, t, hi, pg, bits, st, bad);
    if (bad) begin ef = 1; return; end
    tbl = hi ? bhi : blo;
    for (int l = st; l <= 3; l++) begin
      a = ent_addr(tbl, v, pg, l);
      if (er == 0) efirst = a;
      er++;
      d = mem_rd(a);
      if (d[1:0] != 2'b11) begin ef = 1; return; end
      if (l == 3) epa = ((d >> pg) << pg) | (v % (64'd1 << pg));
      else tbl = (d >> pg) << pg;
    end
  endfunction

  // lays a descriptor chain for v; bad_lvl picks a level to corrupt (4 = none)
  task automatic build_map(input logic [63:0] v, input logic [63:0] t,
                           inout logic [63:0] blo, inout logic [63:0] bhi,
                           input int bad_lvl, input int bad_kind);
    bit hi, bad;
    int pg, bits, st;
    logic [63:0] nxt, tbl, a, d, junk;
    mem.delete();
    cfg_info(v, t, hi, pg, bits, st, bad);
    if (bad) return;
    nxt = 64'h0000_0040_0000_0000 + (64'({$urandom} % 256) << 16);
    tbl = nxt;
    nxt += 64'd1 << pg;
    if (hi) bhi = tbl; else blo = tbl;
    for (int l = st; l <= 3; l++) begin
      a    = ent_addr(tbl, v, pg, l);
      junk = {$urandom, $urandom} & ((64'd1 << pg) - 1) & ~64'd3;
      if (l == 3) begin
        d = ((({$urandom, $urandom} & 64'h0000_FFFF_FFFF_FFFF) >> pg) << pg) | junk | 64'd3;
      end else begin
        d   = nxt | junk | 64'd3;
        tbl = nxt;
        nxt += 64'd1 << pg;
      end
      if (l == bad_lvl) d[1:0] = (bad_kind == 1) ? 2'b01 : ((bad_kind == 2) ? 2'b10 : 2'b00);
      mem[a] = d;
    end
  endtask

  task automatic run_walk(input logic [63:0] v, input bit en, input logic [63:0] t,
                          input logic [63:0] blo, input logic [63:0] bhi,
                          input bit poke, input string ctx);
    bit ef;
    logic [63:0] epa, efirst, prev_pa;
    int er, dc0, n;
    ref_walk(v, en, t, blo, bhi, ef, epa, er, efirst);
    @(negedge clk);
    prev_pa = pa;
    reads_seen = 0;
    dc0 = done_cnt;
    va = v; mmu_en = en; tcr = t; base_lo = blo; base_hi = bhi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      if (poke && n == 2) begin
        start = 1'b1; mmu_en = 1'b0; va = ~v;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done, {ctx, " R10 walk finished"}, 64'(done), 64'd1);
    chk(!busy, {ctx, " R10 not busy at done"}, 64'(busy), 64'd0);
    chk(fault == ef, {ctx, " R8 fault outcome"}, 64'(fault), 64'(ef));
    if (!ef) chk(pa == epa, {ctx, " R9 physical address"}, pa, epa);
    else     chk(pa == prev_pa, {ctx, " R10 pa held on fault"}, pa, prev_pa);
    chk(reads_seen == er, {ctx, " R7 read count"}, 64'(reads_seen), 64'(er));
    if (er > 0) chk(first_addr == efirst, {ctx, " R2 R6 first entry address"}, first_addr, efirst);
    if (!en) chk(reads_seen == 0 && pa == v, {ctx, " R1 identity without reads"}, pa, v);
    @(negedge clk);
    chk(!done, {ctx, " R10 done lasts one cycle"}, 64'(done), 64'd0);
    if (poke) chk(done_cnt == dc0 + 1, {ctx, " R10 start ignored while busy"},
                  64'(done_cnt), 64'(dc0 + 1));
  endtask

  function automatic logic [63:0] mk_tcr(input int g_lo, input int g_hi,
                                         input int sz_lo, input int sz_hi);
    logic [63:0] t;
    t = {$urandom, $urandom};
    t[5:0]   = 6'(sz_lo);
    t[21:16] = 6'(sz_hi);
    t[15:14] = (g_lo == 0) ? 2'b00 : ((g_lo == 1) ? 2'b10 : 2'b01);
    t[31:30] = (g_hi == 0) ? 2'b10 : ((g_hi == 1) ? 2'b01 : 2'b11);
    return t;
  endfunction

  function automatic logic [63:0] canon(input logic [63:0] v, input bit hi, input int sz);
    logic [63:0] r;
    r = v;
    for (int b = 64 - sz; b < 64; b++) r[b] = hi;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v, t, blo, bhi;
    int dc0, szl, szh, gl, gh, bl, bk;
    bit hi;
    void'($urandom(32'd20250823));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !rd_valid && pa == 64'd0, "R12 reset state", pa, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 translation off
    run_walk(64'hDEAD_BEEF_0123_4567, 1'b0, 64'd0, 64'd0, 64'd0, 1'b0, "R1 off");

    // 4K lower, size 16 -> start level 0
    blo = 0; bhi = 64'h0000_0090_0000_0000;
    t = mk_tcr(0, 0, 16, 16);
    v = 64'h0000_1234_5678_9ABC;
    build_map(v, t, blo, bhi, 4, 0);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R7 4K level0");

    // 4K upper, size 35 -> start level 2
    t = mk_tcr(0, 0, 16, 35);
    v = canon(64'h0000_0000_1234_5ABC, 1'b1, 35);
    build_map(v, t, blo, bhi, 4, 0);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R2 R5 upper 4K level2");

    // 64K lower, size 16 -> level 1; 16K upper, size 20
    t = mk_tcr(2, 1, 16, 20);
    v = 64'h0000_7654_3210_FEDC;
    build_map(v, t, blo, bhi, 4, 0);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R4 lower 64K");
    v = canon(64'h0000_0123_4567_89AB, 1'b1, 20);
    build_map(v, t, blo, bhi, 4, 0);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R5 upper 16K");

    // reserved granule codes
    t = mk_tcr(0, 0, 16, 16); t[15:14] = 2'b11;
    run_walk(64'h0000_0000_0000_1000, 1'b1, t, blo, bhi, 1'b0, "R4 reserved lower");
    t = mk_tcr(0, 0, 16, 16); t[31:30] = 2'b00;
    run_walk(64'hFFFF_0000_0000_1000, 1'b1, t, blo, bhi, 1'b0, "R5 reserved upper");

    // non-canonical addresses in both halves
    t = mk_tcr(0, 0, 16, 16);
    run_walk(64'h0001_0000_0000_0000, 1'b1, t, blo, bhi, 1'b0, "R3 lower noncanonical");
    run_walk(64'hFFFE_8000_0000_0000, 1'b1, t, blo, bhi, 1'b0, "R3 upper noncanonical");

    // bad descriptors: invalid at first level, block at level 3
    v = 64'h0000_0ABC_DEF0_1234;
    build_map(v, t, blo, bhi, 0, 0);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R8 invalid descriptor");
    build_map(v, t, blo, bhi, 3, 1);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R8 block descriptor");
    build_map(v, t, blo, bhi, 2, 2);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R8 code 10 descriptor");

    // start while busy is ignored
    build_map(v, t, blo, bhi, 4, 0);
    run_walk(v, 1'b1, t, blo, bhi, 1'b1, "R10 poke");

    // reset in the middle of a walk
    build_map(v, t, blo, bhi, 4, 0);
    @(negedge clk);
    reads_seen = 0;
    dc0 = done_cnt;
    va = v; mmu_en = 1'b1; tcr = t; base_lo = blo; base_hi = bhi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (reads_seen == 0) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_valid && !done, "R12 idle during reset", 64'(busy), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(done_cnt == dc0, "R12 no done after mid-walk reset", 64'(done_cnt), 64'(dc0));
    chk(!busy, "R12 stays idle", 64'(busy), 64'd0);
    run_walk(v, 1'b1, t, blo, bhi, 1'b0, "R12 walk after reset");

    // constrained random walks
    for (int i = 0; i < 300; i++) begin
      gl  = $urandom % 3;
      gh  = $urandom % 3;
      szl = 16 + ($urandom % 24);
      szh = 16 + ($urandom % 24);
      t   = mk_tcr(gl, gh, szl, szh);
      hi  = $urandom % 2;
      v   = canon({$urandom, $urandom}, hi, hi ? szh : szl);
      if ($urandom % 8 == 0) v[62] = ~hi;
      blo = {$urandom, $urandom} & ~64'hFFFF;
      bhi = {$urandom, $urandom} & ~64'hFFFF;
      bl  = ($urandom % 4 == 0) ? int'($urandom % 4) : 4;
      bk  = $urandom % 3;
      build_map(v, t, blo, bhi, bl, bk);
      run_walk(v, ($urandom % 10) != 0, t, blo, bhi, ($urandom % 8) == 0, "R6 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule